// File: doc/BRIEF.md
# Flash self-write unlock controller

This block stands between a processor's register-write bus and the nonvolatile program-memory engine. It stops any erase or program operation from starting by accident. The processor must first write a two-byte key to a key register, then set a start bit in a control register, with no other write in between. When that happens, the block emits a one-cycle start pulse that carries the selected operation code.

After the pulse, the core must throw away whatever it fetches in the next two instruction slots, which makes those slots forced no-operations. For row erase and for the two latch-commit operations, a stall output then holds the core until a modelled operation timer runs out. Loading the write latches causes only the two discarded slots, after which execution continues at once. The start bit can be read back. It reads as 1 from the accepted start until the operation is over.

Top module: `flash_unlock_ctrl`

## Requirements
- R1: After synchronous reset, `stall_o`, `discard_o` and `op_start_o` are low and `ctrl_rd_o` reads zero.
- R2: The sequence is a write of 0x55 to the key address (`KEY_ADDR`, default 0), then a write of 0xAA to the key address, then a control write (`CTRL_ADDR`, default 1) with bit 0 set. This sequence raises `op_start_o` for exactly one cycle, the cycle after the control write, with `op_code_o` equal to control bits [2:1].
- R3: A bus write that breaks the order aborts the sequence, and a start write that follows it is ignored. Such a write can be a wrong key value, the two keys in reverse order, a write to any other address, or a control write with bit 0 clear. A fresh 0x55 key write always restarts the sequence at its second step.
- R4: A start write with no completed key sequence produces no pulse, no discard and no stall, and `ctrl_rd_o` bit 0 stays 0.
- R5: `discard_o` is high for exactly the two cycles that begin with the `op_start_o` cycle.
- R6: The operation codes are 00 = row erase, 10 = commit latches to program memory and 11 = commit latches to the ID area. For these codes, `stall_o` is high for exactly `STALL_CYCLES` cycles, starting in the cycle right after the second discard cycle.
- R7: For code 01 (latch load), `stall_o` never rises, and the block is idle again right after the second discard cycle.
- R8: `ctrl_rd_o` bit 0 is 1 from the `op_start_o` cycle until the operation ends, and then returns to 0 by itself. `ctrl_rd_o` bits [2:1] show the operation selected. The upper bits read 0.
- R9: A key sequence is consumed by its launch. A later start write needs a new key sequence.
- R10: A start write while an operation is in progress starts nothing, even after a complete key sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_addr | input | AW | Register address of the write |
| bus_wdata | input | DW | Write data |
| stall_o | output | 1 | Holds the core while an erase or commit runs |
| discard_o | output | 1 | Core must discard the fetched instruction (forced NOP) |
| op_start_o | output | 1 | One-cycle pulse when an operation is launched |
| op_code_o | output | 2 | Operation code of the launched operation |
| ctrl_rd_o | output | DW | Control register read value: bit 0 start/busy, bits [2:1] operation |

## Verification
Every output is taken from a register, so all results appear in the first cycle after the write strobe is sampled. That first cycle carries the start pulse, the first discard slot and the set start bit. The second discard slot follows one cycle later. The stall then covers the next `STALL_CYCLES` cycles, and the start bit clears in the cycle after that. The bench writes on falling edges and reads on later falling edges. It walks a cycle index from zero, which is the cycle after the control write, and compares every output at each index against values computed from the operation code and the stall length. Abort and ignore cases are observed over a few cycles after the offending write.

// File: rtl/flash_unlock_pkg.sv
package flash_unlock_pkg;

  typedef enum logic [1:0] {
    OP_ERASE  = 2'b00,
    OP_LOAD   = 2'b01,
    OP_PROG   = 2'b10,
    OP_USERID = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    K_IDLE  = 2'b00,
    K_FIRST = 2'b01,
    K_ARMED = 2'b10
  } key_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'b00,
    PH_NOP1 = 2'b01,
    PH_NOP2 = 2'b10,
    PH_BUSY = 2'b11
  } phase_e;

  function automatic logic op_stalls(op_e op);
    return op != OP_LOAD;
  endfunction

endpackage

// File: rtl/fu_key_fsm.sv
module fu_key_fsm
  import flash_unlock_pkg::*;
#(
  parameter int DW = 8,
  parameter logic [DW-1:0] KEY1 = 8'h55,
  parameter logic [DW-1:0] KEY2 = 8'hAA
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          any_wr,
  input  logic          key_wr,
  input  logic          ctrl_wr,
  input  logic [DW-1:0] wdata,
  output logic          armed
);

  key_e state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= K_IDLE;
    end else if (key_wr && wdata == KEY1) begin
      state <= K_FIRST;
    end else if (key_wr && state == K_FIRST && wdata == KEY2) begin
      state <= K_ARMED;
    end else if (any_wr) begin
      state <= K_IDLE;
    end
  end

  assign armed = (state == K_ARMED);

  // R2
  armed_from_first_chk: assert property (@(posedge clk) disable iff (rst)
    (state == K_ARMED && $past(state) != K_ARMED) |-> ($past(state) == K_FIRST && $past(key_wr)));

  // R9
  consumed_chk: assert property (@(posedge clk) disable iff (rst)
    (state == K_ARMED && ctrl_wr) |=> state == K_IDLE);

endmodule

// File: rtl/fu_op_seq.sv
module fu_op_seq
  import flash_unlock_pkg::*;
#(
  parameter int STALL_CYCLES = 40000,
  localparam int CNT_W = $clog2(STALL_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic launch,
  input  op_e  op_in,
  output logic busy,
  output logic discard,
  output logic stall,
  output logic op_start,
  output op_e  op_code
);

  phase_e     phase;
  logic [CNT_W-1:0] cnt;
  logic       accept;

  assign accept = launch && (phase == PH_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      op_start <= 1'b0;
      op_code  <= OP_ERASE;
    end else begin
      op_start <= accept;
      case (phase)
        PH_IDLE: if (accept) begin
          phase   <= PH_NOP1;
          op_code <= op_in;
        end
        PH_NOP1: phase <= PH_NOP2;
        PH_NOP2: begin
          if (op_stalls(op_code)) begin
            phase <= PH_BUSY;
            cnt   <= CNT_W'(STALL_CYCLES - 1);
          end else begin
            phase <= PH_IDLE;
          end
        end
        default: begin
          if (cnt == '0) phase <= PH_IDLE;
          else           cnt   <= cnt - 1'b1;
        end
      endcase
    end
  end

  assign busy    = (phase != PH_IDLE);
  assign discard = (phase == PH_NOP1) || (phase == PH_NOP2);
  assign stall   = (phase == PH_BUSY);

  // R5
  nop_pair_chk: assert property (@(posedge clk) disable iff (rst)
    phase == PH_NOP1 |=> phase == PH_NOP2);

  // R7
  load_no_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_NOP2 && op_code == OP_LOAD) |=> phase == PH_IDLE);

  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    phase == PH_BUSY |-> cnt < CNT_W'(STALL_CYCLES));

  // R6
  stall_after_nop_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(stall) |-> $past(phase) == PH_NOP2);

  // R10
  busy_launch_chk: assert property (@(posedge clk) disable iff (rst)
    (launch && busy) |=> !op_start);

endmodule

// File: rtl/flash_unlock_ctrl.sv
module flash_unlock_ctrl
  import flash_unlock_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8,
  parameter logic [AW-1:0] KEY_ADDR  = 4'd0,
  parameter logic [AW-1:0] CTRL_ADDR = 4'd1,
  parameter int STALL_CYCLES = 40000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic          stall_o,
  output logic          discard_o,
  output logic          op_start_o,
  output logic [1:0]    op_code_o,
  output logic [DW-1:0] ctrl_rd_o
);

  logic key_wr, ctrl_wr, armed, launch, busy;
  logic [1:0] sel_q;
  op_e  code;

  assign key_wr  = bus_we && (bus_addr == KEY_ADDR);
  assign ctrl_wr = bus_we && (bus_addr == CTRL_ADDR);
  assign launch  = ctrl_wr && bus_wdata[0] && armed;

  fu_key_fsm #(.DW(DW), .KEY1(DW'(8'h55)), .KEY2(DW'(8'hAA))) u_key (
    .clk(clk), .rst(rst), .any_wr(bus_we), .key_wr(key_wr),
    .ctrl_wr(ctrl_wr), .wdata(bus_wdata), .armed(armed)
  );

  fu_op_seq #(.STALL_CYCLES(STALL_CYCLES)) u_seq (
    .clk(clk), .rst(rst), .launch(launch), .op_in(op_e'(bus_wdata[2:1])),
    .busy(busy), .discard(discard_o), .stall(stall_o),
    .op_start(op_start_o), .op_code(code)
  );

  always_ff @(posedge clk) begin
    if (rst)                  sel_q <= 2'b00;
    else if (ctrl_wr && !busy) sel_q <= bus_wdata[2:1];
  end

  assign op_code_o = code;
  assign ctrl_rd_o = {{(DW-3){1'b0}}, sel_q, busy};

  // R4
  start_needs_key_chk: assert property (@(posedge clk) disable iff (rst)
    op_start_o |-> $past(armed));

  // R2
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    op_start_o |=> !op_start_o);

  // R8
  sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(sel_q));

  // R6
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(stall_o && discard_o));

endmodule

// File: tb/sim_flash_unlock_ctrl.sv
module sim_flash_unlock_ctrl;

  localparam int N = 12;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_we = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       stall_o, discard_o, op_start_o;
  logic [1:0] op_code_o;
  logic [7:0] ctrl_rd_o;

  int n_vec = 0;
  int n_bad = 0;
  int pulses = 0;
  bit done = 0;

  always #5 clk = ~clk;

  flash_unlock_ctrl #(.STALL_CYCLES(N)) u0 (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .stall_o(stall_o), .discard_o(discard_o),
    .op_start_o(op_start_o), .op_code_o(op_code_o), .ctrl_rd_o(ctrl_rd_o)
  );

  always @(negedge clk) if (!rst && op_start_o) pulses++;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic expect_quiet(string req);
    for (int k = 0; k < 4; k++) begin
      chk(req, {29'd0, op_start_o, discard_o, ctrl_rd_o[0]}, 32'd0);
      @(negedge clk);
    end
  endtask

  task automatic run_op(logic [1:0] op, logic [4:0] upper);
    bit stalls = (op != 2'b01);
    int busy_len = stalls ? N + 2 : 2;
    wr(4'd0, 8'h55);
    wr(4'd0, 8'hAA);
    wr(4'd1, {upper, op, 1'b1});
    for (int k = 0; k < N + 4; k++) begin
      chk("R2 start pulse", op_start_o, k == 0);
      if (k == 0) chk("R2 op code", op_code_o, op);
      chk("R5 discard", discard_o, k < 2);
      if (stalls) chk("R6 stall", stall_o, (k >= 2) && (k < N + 2));
      else        chk("R7 no stall", stall_o, 0);
      chk("R8 readback", ctrl_rd_o, {5'd0, op, (k < busy_len) ? 1'b1 : 1'b0});
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(negedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int p0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk("R1 reset outs", {29'd0, stall_o, discard_o, op_start_o}, 32'd0);
    chk("R1 reset rd", ctrl_rd_o, 32'd0);

    // R2 R5 R6 R7 R8: all operation codes, two upper-bit patterns
    for (int op = 0; op < 4; op++) begin
      run_op(2'(op), 5'b00000);
      run_op(2'(op), 5'b10101);
    end

    // R4: start without key
    wr(4'd1, 8'h01);
    expect_quiet("R4 no key");
    // R3: wrong key value
    wr(4'd0, 8'h55); wr(4'd0, 8'hAB); wr(4'd1, 8'h01);
    expect_quiet("R3 wrong key");
    // R3: reversed order
    wr(4'd0, 8'hAA); wr(4'd0, 8'h55); wr(4'd1, 8'h01);
    expect_quiet("R3 reversed");
    // R3: foreign address between keys
    wr(4'd0, 8'h55); wr(4'd2, 8'h00); wr(4'd0, 8'hAA); wr(4'd1, 8'h01);
    expect_quiet("R3 foreign write");
    // R3: stray key write after arming
    wr(4'd0, 8'h55); wr(4'd0, 8'hAA); wr(4'd0, 8'h00); wr(4'd1, 8'h01);
    expect_quiet("R3 stray key");
    // R3: control write without start while armed
    wr(4'd0, 8'h55); wr(4'd0, 8'hAA); wr(4'd1, 8'h00); wr(4'd1, 8'h01);
    expect_quiet("R3 ctrl no start");
    // R3: repeated 0x55 restarts and then launches
    p0 = pulses;
    wr(4'd0, 8'h55); wr(4'd0, 8'h55); wr(4'd0, 8'hAA); wr(4'd1, 8'h03);
    chk("R3 restart launches", op_start_o, 1);
    chk("R3 restart code", op_code_o, 2'b01);
    repeat (4) @(negedge clk);

    // R9: key consumed by launch
    run_op(2'b01, 5'd0);
    wr(4'd1, 8'h03);
    expect_quiet("R9 key consumed");

    // R10: full key sequence and start while busy
    p0 = pulses;
    wr(4'd0, 8'h55); wr(4'd0, 8'hAA); wr(4'd1, 8'h01);
    wr(4'd0, 8'h55); wr(4'd0, 8'hAA); wr(4'd1, 8'h05);
    repeat (N + 4) @(negedge clk);
    chk("R10 single pulse", pulses - p0, 1);
    chk("R10 idle after", ctrl_rd_o, 32'd0);
    wr(4'd1, 8'h05);
    expect_quiet("R9 after busy");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule